// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual page number into a physical page address for a processor whose memory management is enabled. It fetches a descriptor from a per-context root table, then descends through up to three levels of page tables over a single-word memory port. The walk may end on a leaf at the first, second or third level, which gives 16 MB, 256 KB or 4 KB pages. On the leaf it checks the access against the entry's 3-bit permission field. It writes the referenced and modified bits back into the table when they need to change. It returns the physical address, a page-size code and the granted rights, or a fault code.

With translation off, the address passes straight through. A boot option sends instruction fetches to a fixed ROM window instead. Every fault loads a fault status register and a fault address register. A no-fault option lets user-mode accesses go through despite a permission violation. The block takes one request at a time and ends each one with a single-cycle completion pulse.

Top module: `pgw_walker`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low, and `fsr` and `far` read zero.
- R2: When `cfg_enable` is low, an accepted request completes at the first clock edge after acceptance. It returns no fault, `rsp_paddr` = {4'b0, vpn, 12'h000}, `rsp_psize` = 0 and `rsp_perm` = 3'b111. The permission encoding is bit0 read, bit1 write, bit2 execute.
- R3: With `cfg_enable` low and `cfg_boot` high, a pure fetch (fetch=1, write=0) returns ROM_BASE | {vpn[6:0], 12'h000} with `rsp_perm` = 3'b101. Any other access still passes through as in R2.
- R4: The root descriptor is read at ({cfg_root, 4'h0} + cfg_ctx*4). The table at level 1, 2 and 3 is indexed by vpn[19:12], vpn[11:6] and vpn[5:0] respectively, each index scaled by 4 bytes.
- R5: The entry type is held in bits [1:0]: 0 invalid, 1 pointer, 2 leaf, 3 reserved. A pointer's next table base is {entry[31:2], 6'b0}.
- R6: A leaf at level 1, 2 or 3 gives `rsp_psize` 2, 1 or 0. It also gives `rsp_paddr` = {entry[31:8], 12'h000} plus {vpn[11:0],12'h0}, {vpn[5:0],12'h0} or 0, respectively.
- R7: A walk fault returns `rsp_code` = level<<8 | type<<2. The type is 1 for an invalid entry and 4 for a bad entry. A bad entry is a leaf or reserved entry at level 0, a reserved entry at levels 1 and 2, or a pointer at level 3.
- R8: With access index A = write<<2 | fetch<<1 | supervisor and permission field entry[4:2], a denied leaf access faults with code 8 (missing right) or 12 (user access to fields 6 and 7).
- R9: With `cfg_nofault` high, a permission denial on a user access completes as a success. A supervisor denial still faults.
- R10: On a granted access, the leaf is written back with bit 5 (referenced) set if it was clear. On a write it also gets bit 6 (modified) set if that was clear. Nothing is written when neither bit changes.
- R11: Granted rights follow the permission field for the access's privilege level, with write removed when the modified bit is clear after the update.
- R12: On a fault, `fsr` becomes (A<<5) | code | 2, ORed with 1 if `fsr` was nonzero before, and `far` takes the page address. A `fsr_ack` pulse clears `fsr`.
- R13: `busy` is high while a walk is in progress, and requests presented then are ignored. `done` is a one-cycle pulse. A memory request holds its address until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Translation enabled |
| cfg_boot | input | 1 | Boot mode: fetches go to the ROM window |
| cfg_nofault | input | 1 | Suppress user permission faults |
| cfg_root | input | 32 | Root table pointer (byte address >> 4) |
| cfg_ctx | input | CTX_W | Current context number |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_vpn | input | 20 | Virtual page number (address bits 31:12) |
| req_write | input | 1 | Write access |
| req_fetch | input | 1 | Instruction fetch |
| req_super | input | 1 | Supervisor access |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Request faulted |
| rsp_code | output | 10 | Fault code |
| rsp_paddr | output | 36 | Physical page address |
| rsp_psize | output | 2 | 0: 4 KB, 1: 256 KB, 2: 16 MB |
| rsp_perm | output | 3 | Granted rights {exec, write, read} |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 36 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |
| fsr_ack | input | 1 | Clear fault status |
| fsr | output | 16 | Fault status register |
| far | output | 32 | Fault address register |

## Verification
The bound checker watches every cycle for the following. A completion pulse never coincides with `busy` and lasts one cycle. A pending memory access keeps its address and direction until acknowledged. Every write-back carries the referenced bit. Each detected fault is followed by a faulting completion whose code has clear low bits, and every fault leaves the status valid bit set. The arithmetic outcomes can only be shown by the bench's scenarios, which compare against its own table walk: descriptor addressing, page size and offset, the access matrix, no-fault suppression, modified-bit stripping, the overwrite flag and the ignored overlapping request.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
package pgw_pkg;
  localparam int PA_W    = 36;
  localparam int CODE_W  = 10;
  localparam int FSR_W   = 16;
  localparam int ACC_LSB = 2;
  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;

  typedef enum logic [1:0] {ET_INV = 2'd0, ET_PTR = 2'd1, ET_PTE = 2'd2, ET_RSV = 2'd3} ent_t;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_READ = 2'd1, ST_WRITE = 2'd2} st_t;

  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_XLATE   = 3'd4;

  // rights as {exec, write, read}
  function automatic logic [2:0] page_rights(input logic [2:0] acc, input logic sup);
    logic [2:0] r;
    unique case (acc)
      3'd0: r = 3'b001;
      3'd1: r = 3'b011;
      3'd2: r = 3'b101;
      3'd3: r = 3'b111;
      3'd4: r = 3'b100;
      3'd5: r = sup ? 3'b011 : 3'b001;
      3'd6: r = sup ? 3'b101 : 3'b000;
      default: r = sup ? 3'b111 : 3'b000;
    endcase
    return r;
  endfunction

  // ai = {write, fetch, supervisor}; 0 ok, 8 protection, 12 privilege
  function automatic logic [3:0] access_verdict(input logic [2:0] ai, input logic [2:0] acc);
    logic [2:0] need;
    logic [2:0] have;
    need = {ai[1], ai[2], ~ai[2] & ~ai[1]};
    have = page_rights(acc, ai[0]);
    if (!ai[0] && acc[2:1] == 2'b11) return 4'd12;
    if ((need & ~have) != 3'b000) return 4'd8;
    return 4'd0;
  endfunction

  function automatic logic [CODE_W-1:0] walk_fault_code(input logic [1:0] lvl, input logic [2:0] ft);
    return {lvl, 3'b000, ft, 2'b00};
  endfunction

  function automatic logic [PA_W-1:0] next_table(input logic [29:0] base_field);
    return {base_field, 6'b000000};
  endfunction

  function automatic logic [PA_W-1:0] leaf_paddr(input logic [23:0] ppn, input logic [11:0] vlow,
                                                 input logic [1:0] lvl);
    logic [PA_W-1:0] off;
    unique case (lvl)
      2'd1:    off = {12'b0, vlow, 12'b0};
      2'd2:    off = {18'b0, vlow[5:0], 12'b0};
      default: off = '0;
    endcase
    return {ppn, 12'b0} + off;
  endfunction
endpackage

// File: rtl/pgw_access_check.sv
`timescale 1ns/1ps
module pgw_access_check
  import pgw_pkg::*;
(
  input  logic [2:0]  ai,
  input  logic [31:0] pte,
  input  logic        nofault,
  output logic        perm_fault,
  output logic [3:0]  err_code,
  output logic [2:0]  granted,
  output logic        wb_need,
  output logic [31:0] wb_data
);
  logic [2:0] acc;
  logic [2:0] base_rights;

  assign acc        = pte[ACC_LSB +: 3];
  assign err_code   = access_verdict(ai, acc);
  assign perm_fault = (err_code != 4'd0) && !(nofault && !ai[0]);

  always_comb begin
    wb_data = pte;
    wb_data[REF_BIT] = 1'b1;
    if (ai[2]) wb_data[MOD_BIT] = 1'b1;
  end

  assign wb_need     = (wb_data != pte);
  assign base_rights = page_rights(acc, ai[0]);
  assign granted     = wb_data[MOD_BIT] ? base_rights : (base_rights & 3'b101);
endmodule

// File: rtl/pgw_fault_log.sv
`timescale 1ns/1ps
module pgw_fault_log
  import pgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              log_en,
  input  logic [2:0]        ai,
  input  logic [CODE_W-1:0] code,
  input  logic [19:0]       vpn,
  input  logic              ack,
  output logic [FSR_W-1:0]  fsr,
  output logic [31:0]       far
);
  logic [FSR_W-1:0] fsr_q;
  logic [19:0]      far_vpn_q;
  logic [FSR_W-1:0] fsr_next;

  assign fsr_next = {{(FSR_W-1){1'b0}}, |fsr_q}
                  | {{(FSR_W-8){1'b0}}, ai, 5'b00000}
                  | {{(FSR_W-CODE_W){1'b0}}, code}
                  | {{(FSR_W-2){1'b0}}, 2'b10};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_q     <= '0;
      far_vpn_q <= '0;
    end else if (log_en) begin
      fsr_q     <= fsr_next;
      far_vpn_q <= vpn;
    end else if (ack) begin
      fsr_q <= '0;
    end
  end

  assign fsr = fsr_q;
  assign far = {far_vpn_q, 12'h000};
endmodule

// File: rtl/pgw_walker.sv
`timescale 1ns/1ps
module pgw_walker
  import pgw_pkg::*;
#(
  parameter logic [35:0] ROM_BASE = 36'h0_FF00_0000,
  parameter int          CTX_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_boot,
  input  logic              cfg_nofault,
  input  logic [31:0]       cfg_root,
  input  logic [CTX_W-1:0]  cfg_ctx,
  input  logic              req_valid,
  input  logic [19:0]       req_vpn,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic              req_super,
  output logic              busy,
  output logic              done,
  output logic              rsp_fault,
  output logic [CODE_W-1:0] rsp_code,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_psize,
  output logic [2:0]        rsp_perm,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              fsr_ack,
  output logic [FSR_W-1:0]  fsr,
  output logic [31:0]       far
);
  localparam int          IDX_W    = 8;
  localparam logic [1:0]  LAST_LVL = 2'd3;

  st_t         state;
  logic [1:0]  lvl;
  logic [19:0] vpn_q;
  logic [2:0]  ai_q;
  logic [PA_W-1:0] addr_q;
  logic [31:0] wdata_q;
  logic        we_q;

  // named internal events
  logic        accept, rd_ack, wr_ack, go_next, is_leaf, walk_err, fault_now;
  logic        perm_fault, wb_need;
  logic [3:0]  err_code;
  logic [2:0]  granted, walk_type;
  logic [31:0] wb_data;
  logic [CODE_W-1:0] fault_code;
  logic [IDX_W-1:0]  next_idx;
  logic [PA_W-1:0]   next_addr, root_addr, bypass_pa;
  ent_t        etype;

  assign accept    = req_valid && (state == ST_IDLE);
  assign etype     = ent_t'(mem_rdata[1:0]);
  assign rd_ack    = (state == ST_READ) && mem_ack;
  assign wr_ack    = (state == ST_WRITE) && mem_ack;
  assign go_next   = rd_ack && (etype == ET_PTR) && (lvl != LAST_LVL);
  assign is_leaf   = rd_ack && (etype == ET_PTE) && (lvl != 2'd0);
  assign walk_err  = rd_ack && !go_next && !is_leaf;
  assign walk_type = (etype == ET_INV) ? FT_INVALID : FT_XLATE;
  assign fault_now = walk_err || (is_leaf && perm_fault);
  assign fault_code = walk_err ? walk_fault_code(lvl, walk_type) : {{(CODE_W-4){1'b0}}, err_code};

  always_comb begin
    unique case (lvl)
      2'd0:    next_idx = vpn_q[19:12];
      2'd1:    next_idx = {2'b00, vpn_q[11:6]};
      default: next_idx = {2'b00, vpn_q[5:0]};
    endcase
  end

  assign next_addr = next_table(mem_rdata[31:2]) + {{(PA_W-IDX_W-2){1'b0}}, next_idx, 2'b00};
  assign root_addr = {cfg_root, 4'h0} + {{(PA_W-CTX_W-2){1'b0}}, cfg_ctx, 2'b00};
  assign bypass_pa = (cfg_boot && req_fetch && !req_write)
                   ? (ROM_BASE | {17'b0, req_vpn[6:0], 12'h000})
                   : {4'h0, req_vpn, 12'h000};

  pgw_access_check u_chk_acc (
    .ai(ai_q), .pte(mem_rdata), .nofault(cfg_nofault),
    .perm_fault(perm_fault), .err_code(err_code), .granted(granted),
    .wb_need(wb_need), .wb_data(wb_data)
  );

  pgw_fault_log u_log (
    .clk(clk), .rst_n(rst_n), .log_en(fault_now), .ai(ai_q), .code(fault_code),
    .vpn(vpn_q), .ack(fsr_ack), .fsr(fsr), .far(far)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lvl       <= '0;
      vpn_q     <= '0;
      ai_q      <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      we_q      <= 1'b0;
      done      <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_code  <= '0;
      rsp_paddr <= '0;
      rsp_psize <= '0;
      rsp_perm  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          vpn_q <= req_vpn;
          ai_q  <= {req_write, req_fetch, req_super};
          if (cfg_enable) begin
            state  <= ST_READ;
            lvl    <= 2'd0;
            addr_q <= root_addr;
            we_q   <= 1'b0;
          end else begin
            done      <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_code  <= '0;
            rsp_psize <= 2'd0;
            rsp_paddr <= bypass_pa;
            rsp_perm  <= (cfg_boot && req_fetch && !req_write) ? 3'b101 : 3'b111;
          end
        end
        ST_READ: begin
          if (go_next) begin
            lvl    <= lvl + 2'd1;
            addr_q <= next_addr;
          end else if (fault_now) begin
            done      <= 1'b1;
            state     <= ST_IDLE;
            rsp_fault <= 1'b1;
            rsp_code  <= fault_code;
            rsp_paddr <= '0;
            rsp_psize <= '0;
            rsp_perm  <= '0;
          end else if (is_leaf) begin
            rsp_fault <= 1'b0;
            rsp_code  <= '0;
            rsp_paddr <= leaf_paddr(mem_rdata[31:8], vpn_q[11:0], lvl);
            rsp_psize <= LAST_LVL - lvl;
            rsp_perm  <= granted;
            if (wb_need) begin
              state   <= ST_WRITE;
              we_q    <= 1'b1;
              wdata_q <= wb_data;
            end else begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
        ST_WRITE: if (wr_ack) begin
          done  <= 1'b1;
          state <= ST_IDLE;
          we_q  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/pgw_walker_chk.sv
`timescale 1ns/1ps
module pgw_walker_chk
  import pgw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              rsp_fault,
  input logic [CODE_W-1:0] rsp_code,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [PA_W-1:0]   mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic [FSR_W-1:0]  fsr,
  input logic              walk_fault
);
  // R13
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R13
  mem_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy);
  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R10
  wb_ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[REF_BIT]);
  // R7
  fault_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_fault |=> (done && rsp_fault && rsp_code != '0 && rsp_code[1:0] == 2'b00));
  // R12
  fault_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_fault) |-> fsr[1]);
  // R6
  page_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rsp_fault) |-> (rsp_paddr[11:0] == 12'h000));
endmodule

bind pgw_walker pgw_walker_chk u_pgw_walker_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rsp_fault(rsp_fault),
  .rsp_code(rsp_code), .rsp_paddr(rsp_paddr), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .fsr(fsr),
  .walk_fault(fault_now)
);

// File: tb/pgw_walker_bench.sv
`timescale 1ns/1ps
module pgw_walker_bench;
  localparam logic [35:0] ROM = 36'h0_FF00_0000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_enable, cfg_boot, cfg_nofault;
  logic [31:0] cfg_root;
  logic [7:0]  cfg_ctx;
  logic req_valid, req_write, req_fetch, req_super;
  logic [19:0] req_vpn;
  logic busy, done, rsp_fault, mem_req, mem_we, mem_ack, fsr_ack;
  logic [9:0]  rsp_code;
  logic [35:0] rsp_paddr, mem_addr;
  logic [1:0]  rsp_psize;
  logic [2:0]  rsp_perm;
  logic [31:0] mem_wdata, mem_rdata, far;
  logic [15:0] fsr;

  pgw_walker u_pgw_walker (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_boot(cfg_boot),
    .cfg_nofault(cfg_nofault), .cfg_root(cfg_root), .cfg_ctx(cfg_ctx),
    .req_valid(req_valid), .req_vpn(req_vpn), .req_write(req_write),
    .req_fetch(req_fetch), .req_super(req_super), .busy(busy), .done(done),
    .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
    .rsp_psize(rsp_psize), .rsp_perm(rsp_perm), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .fsr_ack(fsr_ack), .fsr(fsr), .far(far)
  );

  // memory model
  logic [31:0] mem [logic [35:0]];
  function automatic logic [31:0] rd(input logic [35:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= 32'h0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr] = mem_wdata;
      else mem_rdata <= rd(mem_addr);
    end else begin
      mem_ack <= 1'b0;
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference model
  int acc_tbl [8][8] = '{
    '{0,0,0,0,8,0,12,12}, '{0,0,0,0,8,0,0,0},
    '{8,8,0,0,0,8,12,12}, '{8,8,0,0,0,8,0,0},
    '{8,0,8,0,8,8,12,12}, '{8,0,8,0,8,0,8,0},
    '{8,8,8,0,8,8,12,12}, '{8,8,8,0,8,8,8,0}};
  logic [2:0] sup_rt [8] = '{3'd1,3'd3,3'd5,3'd7,3'd4,3'd3,3'd5,3'd7};
  logic [2:0] usr_rt [8] = '{3'd1,3'd3,3'd5,3'd7,3'd4,3'd1,3'd0,3'd0};

  logic        exp_fault, exp_wb;
  logic [9:0]  exp_code;
  logic [35:0] exp_pa, exp_wb_addr;
  logic [1:0]  exp_psize;
  logic [2:0]  exp_perm;
  logic [31:0] exp_wb_val, model_far;
  logic [15:0] model_fsr = 16'h0;

  task automatic set_fault(input logic [9:0] code, input logic [2:0] ai, input logic [19:0] vpn);
    exp_fault = 1'b1;
    exp_code  = code;
    model_fsr = ((model_fsr != 0) ? 16'h1 : 16'h0) | (16'(ai) << 5) | 16'(code) | 16'h2;
    model_far = {vpn, 12'h0};
  endtask

  task automatic ref_walk(input logic [19:0] vpn, input logic w, input logic f, input logic s);
    logic [2:0]  ai;
    logic [35:0] a;
    logic [31:0] e, nv;
    logic [7:0]  idx;
    int er;
    ai = {w, f, s};
    exp_fault = 0; exp_code = 0; exp_wb = 0; exp_psize = 0; exp_perm = 0; exp_pa = 0;
    if (!cfg_enable) begin
      if (cfg_boot && f && !w) begin
        exp_pa = ROM | (36'(vpn[6:0]) << 12);
        exp_perm = 3'b101;
      end else begin
        exp_pa = 36'(vpn) << 12;
        exp_perm = 3'b111;
      end
      return;
    end
    a = (36'(cfg_root) << 4) + 36'(cfg_ctx) * 4;
    e = rd(a);
    if (e[1:0] != 2'd1) begin
      set_fault((e[1:0] == 0) ? 10'h004 : 10'h010, ai, vpn);
      return;
    end
    for (int L = 1; L <= 3; L++) begin
      idx = (L == 1) ? vpn[19:12] : (L == 2) ? {2'b0, vpn[11:6]} : {2'b0, vpn[5:0]};
      a = (36'(e & 32'hFFFF_FFFC) << 4) + 36'(idx) * 4;
      e = rd(a);
      if (e[1:0] == 2'd0) begin set_fault(10'(L << 8) | 10'h004, ai, vpn); return; end
      if (e[1:0] == 2'd3 || (e[1:0] == 2'd1 && L == 3)) begin
        set_fault(10'(L << 8) | 10'h010, ai, vpn); return;
      end
      if (e[1:0] == 2'd2) begin
        er = acc_tbl[ai][e[4:2]];
        if (er != 0 && !(cfg_nofault && !s)) begin set_fault(10'(er), ai, vpn); return; end
        nv = e | 32'h20 | (w ? 32'h40 : 32'h0);
        exp_wb = (nv != e); exp_wb_addr = a; exp_wb_val = nv;
        exp_perm = s ? sup_rt[e[4:2]] : usr_rt[e[4:2]];
        if (!nv[6]) exp_perm = exp_perm & 3'b101;
        exp_pa = 36'(e[31:8]) << 12;
        if (L == 1) exp_pa = exp_pa + (36'(vpn[11:0]) << 12);
        if (L == 2) exp_pa = exp_pa + (36'(vpn[5:0]) << 12);
        exp_psize = 2'(3 - L);
        return;
      end
    end
  endtask

  task automatic run(input logic [19:0] vpn, input logic w, input logic f, input logic s, input string tag);
    ref_walk(vpn, w, f, s);
    @(negedge clk);
    req_valid = 1; req_vpn = vpn; req_write = w; req_fetch = f; req_super = s;
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    chk(tag, "fault", rsp_fault, exp_fault);
    if (exp_fault) chk(tag, "code", rsp_code, exp_code);
    else begin
      chk(tag, "paddr", rsp_paddr, exp_pa);
      chk(tag, "psize", rsp_psize, exp_psize);
      chk(tag, "perm", rsp_perm, exp_perm);
      if (exp_wb) chk("R10", "writeback", rd(exp_wb_addr), exp_wb_val);
    end
    chk("R12", "fsr", fsr, model_fsr);
    if (exp_fault) chk("R12", "far", far, model_far);
  endtask

  // pointer chain under root 0x1000, ctx 3; leaf at depth
  task automatic chain(input logic [19:0] vpn, input int depth, input logic [31:0] leaf);
    mem.delete();
    cfg_root = 32'h1000; cfg_ctx = 8'd3;
    mem[36'h1000C] = 32'h0000_2001;
    mem[36'h20000 + 36'(vpn[19:12]) * 4] = (depth == 1) ? leaf : 32'h0000_3001;
    if (depth >= 2) mem[36'h30000 + 36'(vpn[11:6]) * 4] = (depth == 2) ? leaf : 32'h0000_4001;
    if (depth == 3) mem[36'h40000 + 36'(vpn[5:0]) * 4] = leaf;
  endtask

  task automatic build_rand(input logic [19:0] vpn);
    logic [35:0] a;
    logic [31:0] e;
    logic [1:0]  t;
    int tgt;
    int unsigned r;
    mem.delete();
    cfg_root = $urandom; cfg_ctx = 8'($urandom);
    tgt = 1 + int'($urandom % 3);
    a = (36'(cfg_root) << 4) + 36'(cfg_ctx) * 4;
    for (int L = 0; L <= 3; L++) begin
      t = (L < tgt) ? 2'd1 : 2'd2;
      if ($urandom % 10 == 0) t = 2'($urandom);
      r = $urandom;
      e = {r[31:2], t};
      mem[a] = e;
      if (t != 2'd1 || L == 3) break;
      a = (36'(e & 32'hFFFF_FFFC) << 4) +
          36'((L == 0) ? vpn[19:12] : (L == 1) ? {2'b0, vpn[11:6]} : {2'b0, vpn[5:0]}) * 4;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int dones;
    void'($urandom(32'd20240611));
    rst_n = 0; cfg_enable = 0; cfg_boot = 0; cfg_nofault = 0; cfg_root = 0; cfg_ctx = 0;
    req_valid = 0; req_vpn = 0; req_write = 0; req_fetch = 0; req_super = 0; fsr_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1", "busy", busy, 0); chk("R1", "done", done, 0); chk("R1", "mem_req", mem_req, 0);
    chk("R1", "fsr", fsr, 0); chk("R1", "far", far, 0);

    // R2 bypass
    run(20'hABCDE, 1, 0, 0, "R2");
    // R3 boot window
    cfg_boot = 1;
    run(20'h12345, 0, 1, 1, "R3");
    run(20'h12345, 0, 0, 1, "R3");
    cfg_boot = 0;

    cfg_enable = 1;
    // R4 R5: hand-built chains at computed addresses
    chain(20'h5A7C3, 3, 32'h0ABCDE_00 | 32'h6E);
    run(20'h5A7C3, 0, 0, 1, "R4");
    chain(20'h3F0C1, 2, 32'h12345600 | 32'h6E);
    run(20'h3F0C1, 0, 0, 0, "R5");
    chain(20'h81FFF, 1, 32'h77000000 | 32'h6E);
    run(20'h81FFF, 0, 0, 0, "R6");

    // R7 walk faults, R12 overwrite
    mem.delete(); cfg_root = 32'h10; cfg_ctx = 8'd1;
    run(20'h00001, 0, 0, 1, "R7");
    mem[36'h104] = 32'h0000_0002;
    run(20'h00002, 1, 0, 0, "R7");
    chain(20'h11111, 3, 32'h0000_5001);
    run(20'h11111, 0, 1, 1, "R7");
    @(negedge clk); fsr_ack = 1; @(negedge clk); fsr_ack = 0;
    chk("R12", "fsr after ack", fsr, 0);
    model_fsr = 0;

    // R8 R9 permission and no-fault
    chain(20'h22222, 3, 32'h0000_1A00 | (32'd6 << 2) | 32'h62);
    run(20'h22222, 0, 0, 0, "R8");
    cfg_nofault = 1;
    run(20'h22222, 0, 0, 0, "R9");
    chain(20'h22223, 3, 32'h0000_1B00 | (32'd4 << 2) | 32'h62);
    run(20'h22223, 0, 0, 1, "R9");
    cfg_nofault = 0;

    // R10 R11 update and write stripping
    chain(20'h33333, 3, 32'h0000_2C00 | (32'd1 << 2) | 32'h02);
    run(20'h33333, 1, 0, 0, "R10");
    chain(20'h33334, 3, 32'h0000_2D00 | (32'd3 << 2) | 32'h22);
    run(20'h33334, 0, 0, 0, "R11");
    chk("R11", "no write", rd(36'h40000 + 36'd52 * 4), 32'h0000_2D00 | (32'd3 << 2) | 32'h22);

    // R13 request while busy ignored
    chain(20'h44444, 3, 32'h0000_3E00 | (32'd3 << 2) | 32'h62);
    ref_walk(20'h44444, 0, 0, 1);
    @(negedge clk);
    req_valid = 1; req_vpn = 20'h44444; req_write = 0; req_fetch = 0; req_super = 1;
    @(negedge clk);
    chk("R13", "busy", busy, 1);
    req_vpn = 20'h99999;
    @(negedge clk); @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    chk("R13", "first paddr", rsp_paddr, exp_pa);
    dones = 0;
    repeat (8) begin @(negedge clk); if (done) dones++; end
    chk("R13", "extra done", dones, 0);

    // random sweep
    for (int i = 0; i < 400; i++) begin
      logic [19:0] v;
      v = 20'($urandom);
      cfg_enable  = ($urandom % 8) != 0;
      cfg_boot    = ($urandom % 2) == 1;
      cfg_nofault = ($urandom % 4) == 0;
      build_rand(v);
      run(v, 1'($urandom), 1'($urandom), 1'($urandom), "R6");
      if ($urandom % 16 == 0) begin
        @(negedge clk); fsr_ack = 1; @(negedge clk); fsr_ack = 0;
        model_fsr = 0;
        chk("R12", "fsr ack", fsr, 0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule